// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block holds back the completion interrupts of one traffic direction so that a burst of completions is serviced with few interrupts. Two timers work together. The burst timer starts on the first completion after the last interrupt and fires once its threshold is reached, however many completions keep arriving. The idle timer restarts on every completion and fires once the line has been quiet for its threshold. Whichever fires first produces a single-cycle done pulse toward the interrupt cause register, and both timers start over.

Each timer has a control word holding clear, enable and tick-select bits, and a threshold word. To reprogram a timer, software writes the control word with only the clear bit set, then writes the threshold, then writes enable together with the tick select. With tick select set, the timer advances only on an external one-microsecond strobe, so the threshold is in microseconds. Without it, the timer advances every clock. A separate high-watermark cause passes straight through and is never delayed, so the buffer cannot overflow while a done event is being held back. When both timers are disabled, every completion passes straight through as a done pulse.

Top module: `irq_moderator`

## Requirements
- R1: After reset, done_o and hi_o are low and both timers are disabled, so the block starts in pass-through mode.
- R2: With both timers disabled, done_o is high in the cycle after each clock edge that samples evt_i high.
- R3: A write with cfg_we_i high selects by cfg_sel_i: 0 is the burst control word, 1 the burst threshold, 2 the idle control word and 3 the idle threshold. In a control word, bit 0 is clear, bit 1 is enable and bit 2 is tick select. A control write with the clear bit set zeroes that timer and disables it, even when the enable bit is also set.
- R4: With only the burst timer enabled in clock mode and threshold N, a completion sampled at edge E with nothing pending raises done_o after edge E+N+1, even when completions arrive on every cycle.
- R5: With only the idle timer enabled in clock mode and threshold N, done_o rises after edge L+N+1, where L is the last completion edge. Each completion while pending restarts the idle count.
- R6: With tick select set, a timer advances only on edges that sample us_tick_i high.
- R7: A fire raises done_o for exactly one cycle, zeroes both counts and clears the pending state. A completion sampled on the fire edge is absorbed into that interrupt. The next completion starts a new moderation window.
- R8: hi_o equals hi_thr_i as sampled at the previous edge, in every mode, including while a done event is held back.
- R9: With both timers enabled, the first timer to reach its threshold fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| evt_i | input | 1 | Completion event |
| hi_thr_i | input | 1 | High-watermark cause |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | CNT_W | Configuration write data |
| done_o | output | 1 | Moderated done pulse |
| hi_o | output | 1 | High-watermark cause, registered |

## Verification
The assertions assume that us_tick_i is a clean synchronous strobe, and that software does not reprogram a timer in the same cycle that it fires. The bench writes configuration only while nothing is pending and keeps all control writes apart from completion events. It also keeps hi_thr_i low around reset, because the pass-through check on the high-watermark cause looks back one edge.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
  localparam int CTRL_CLR  = 0;
  localparam int CTRL_EN   = 1;
  localparam int CTRL_TSEL = 2;

  localparam logic [1:0] SEL_BURST_CTRL = 2'd0;
  localparam logic [1:0] SEL_BURST_THR  = 2'd1;
  localparam logic [1:0] SEL_IDLE_CTRL  = 2'd2;
  localparam logic [1:0] SEL_IDLE_THR   = 2'd3;

  localparam int NUM_TIMERS = 2;
endpackage

// File: rtl/irqmod_timer.sv
module irqmod_timer
  import irqmod_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter bit RESTART_ON_EVT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_tick_i,
  input  logic             ctrl_we_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             run_i,
  input  logic             evt_i,
  input  logic             zero_i,
  output logic             en_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q, tsel_q;
  logic [CNT_W-1:0] thr_q, cnt_q;
  logic             tick, clr_wr;

  assign tick   = tsel_q ? us_tick_i : 1'b1;
  assign clr_wr = ctrl_we_i && wdata_i[CTRL_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      tsel_q <= 1'b0;
      thr_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= wdata_i[CTRL_EN]   & ~wdata_i[CTRL_CLR];
        tsel_q <= wdata_i[CTRL_TSEL] & ~wdata_i[CTRL_CLR];
      end
      if (thr_we_i) thr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_wr || zero_i || !run_i) cnt_q <= '0;
    else if (RESTART_ON_EVT && evt_i)  cnt_q <= '0;
    else if (en_q && tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign en_o  = en_q;
  assign hit_o = en_q && run_i && (cnt_q >= thr_q);

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (cnt_q == '0 && !en_q));

  // R5
  idle_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RESTART_ON_EVT && run_i && evt_i) |=> (cnt_q == '0));

  // R6
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_q && !us_tick_i && run_i && !evt_i && !zero_i && !ctrl_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irqmod_fire.sv
module irqmod_fire
  import irqmod_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  evt_i,
  input  logic                  hi_thr_i,
  input  logic [NUM_TIMERS-1:0] en_i,
  input  logic [NUM_TIMERS-1:0] hit_i,
  output logic                  pend_o,
  output logic                  fire_o,
  output logic                  done_o,
  output logic                  hi_o
);
  logic pend_q, done_q, hi_q, bypass;

  assign bypass = ~|en_i;
  assign fire_o = pend_q && |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      hi_q <= hi_thr_i;
      if (bypass) begin
        pend_q <= 1'b0;
        done_q <= evt_i;
      end else begin
        done_q <= fire_o;
        pend_q <= fire_o ? 1'b0 : (pend_q | evt_i);
      end
    end
  end

  assign pend_o = pend_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;

  // R7
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !bypass) |=> !done_q);

  // R7
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !pend_q);

  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass && evt_i) |=> done_q);

  // R8
  hi_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_thr_i |=> hi_q);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_tick_i,
  input  logic             evt_i,
  input  logic             hi_thr_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic             done_o,
  output logic             hi_o
);
  logic [NUM_TIMERS-1:0] en, hit;
  logic                  pend, fire;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    // timer 0 is the burst timer, timer 1 the idle timer
    localparam logic [1:0] CSEL = (g == 0) ? SEL_BURST_CTRL : SEL_IDLE_CTRL;
    localparam logic [1:0] TSEL = (g == 0) ? SEL_BURST_THR  : SEL_IDLE_THR;

    irqmod_timer #(
      .CNT_W          (CNT_W),
      .RESTART_ON_EVT (g == 1)
    ) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .us_tick_i (us_tick_i),
      .ctrl_we_i (cfg_we_i && cfg_sel_i == CSEL),
      .thr_we_i  (cfg_we_i && cfg_sel_i == TSEL),
      .wdata_i   (cfg_wdata_i),
      .run_i     (pend),
      .evt_i     (evt_i),
      .zero_i    (fire),
      .en_o      (en[g]),
      .hit_o     (hit[g])
    );
  end

  irqmod_fire u_fire (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .hi_thr_i (hi_thr_i),
    .en_i     (en),
    .hit_i    (hit),
    .pend_o   (pend),
    .fire_o   (fire),
    .done_o   (done_o),
    .hi_o     (hi_o)
  );
endmodule

// File: tb/irq_moderator_tb.sv
`timescale 1ns/1ps
module irq_moderator_tb;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CLR = 16'h1, EN = 16'h2, TS = 16'h4;

  logic clk = 0, rst_n = 0, tick = 0, evt = 0, hi = 0, we = 0;
  logic [1:0] sel = 0;
  logic [CNT_W-1:0] wd = 0;
  logic done_o, hi_o;

  always #2.5 clk = ~clk;

  irq_moderator #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .evt_i(evt), .hi_thr_i(hi),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd), .done_o(done_o), .hi_o(hi_o));

  typedef struct { int edge_n; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_vec = 0, n_err = 0;
  bit mon_en = 0;
  string cur_req = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s edge %0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int e, input string r);
    exp_t x;
    x.edge_n = e; x.req = r;
    q.push_back(x);
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk); #1;
    if (mon_en) begin
      logic exp_d;
      string r;
      exp_d = (q.size() > 0) && (q[0].edge_n == cyc);
      r = exp_d ? q[0].req : cur_req;
      chk(done_o, exp_d, r);
      if (exp_d) void'(q.pop_front());
      chk(hi_o, hi, "R8");
    end
  end

  task automatic drive(input logic e, input logic h, input logic t);
    evt = e; hi = h; tick = t;
    @(negedge clk);
    evt = 0; hi = 0; tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] s, input logic [CNT_W-1:0] d);
    we = 1; sel = s; wd = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog edge %0d actual=hung expected=done", cyc);
    finish_run();
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done_o, 1'b0, "R1");
    chk(hi_o, 1'b0, "R1");
    mon_en = 1;

    // pass-through
    cur_req = "R2";
    push(cyc + 1, "R1"); drive(1, 0, 0);
    push(cyc + 1, "R2"); drive(1, 1, 0);
    push(cyc + 1, "R2"); drive(1, 0, 0);
    drive(0, 1, 0); drive(0, 0, 0);
    push(cyc + 1, "R2"); drive(1, 0, 0);
    idle(4);

    // burst only, thr 5, completions every cycle
    cur_req = "R4";
    wr(0, CLR); wr(1, 5); wr(0, EN); idle(2);
    e0 = cyc + 1;
    push(e0 + 6, "R4"); push(e0 + 13, "R7");
    for (int i = 0; i < 12; i++) drive(1, (i == 3 || i == 4), 0);
    idle(6);

    // clear wins over enable: back to pass-through
    cur_req = "R3";
    wr(0, CLR | EN); idle(1);
    push(cyc + 1, "R3"); drive(1, 0, 0);
    idle(3);

    // idle only, thr 3
    cur_req = "R5";
    wr(2, CLR); wr(3, 3); wr(2, EN); idle(2);
    e0 = cyc + 1;
    push(e0 + 8, "R5");
    drive(1, 0, 0); drive(0, 0, 0); drive(1, 1, 0); drive(0, 0, 0); drive(1, 0, 0);
    idle(8);
    e0 = cyc + 1;
    push(e0 + 4, "R5"); drive(1, 0, 0);
    idle(7);

    // idle with microsecond tick, thr 2
    cur_req = "R6";
    wr(2, CLR); wr(3, 2); wr(2, EN | TS); idle(2);
    e0 = cyc + 1;
    push(e0 + 8, "R6");
    for (int i = 0; i < 12; i++) drive(i == 0, 0, (i == 3 || i == 7));
    idle(3);

    // both enabled: burst thr 6, idle thr 2
    cur_req = "R9";
    wr(0, CLR); wr(1, 6); wr(0, EN);
    wr(2, CLR); wr(3, 2); wr(2, EN); idle(2);
    e0 = cyc + 1;
    push(e0 + 7, "R9"); push(e0 + 12, "R9");
    for (int i = 0; i < 10; i++) drive(1, 0, 0);
    idle(6);

    mon_en = 0;
    while (q.size() > 0) begin
      n_vec++; n_err++;
      $display("FAIL %s edge %0d actual=none expected=done", q[0].req, q[0].edge_n);
      void'(q.pop_front());
    end
    finish_run();
  end
endmodule